// File: doc/BRIEF.md
# Ordered Store Queue with Load Bypass and Fence

This block sits between an in-order core's load/store port and a single-ported memory. A store is parked in a small first-in-first-out queue and acknowledged to the core at once. The queue then drains to memory in the background, oldest entry first. Loads that miss the queue can go to memory ahead of older parked stores, which gives a total-store-order machine. A load that hits the queue is answered from the youngest matching entry.

A mode input can switch the block to strict sequential ordering. In that mode a load that misses waits until every parked store has been written. A fence request completes only when the queue is empty and the memory has acknowledged the last write. Because the core port is in order, nothing behind a fence is accepted until the fence itself is accepted.

Top module: `tso_wbuf`

## Requirements
- R1: A store request (op code 1) is accepted while the queue is not full and the block is not waiting on a load. It is accepted without waiting for memory, and the occupancy count rises by one.
- R2: Queued stores are written to memory one at a time (mem_req_write=1), in exactly the order the core presented them.
- R3: With relaxed ordering in force (ordering latch 0), a load (op code 0) that matches no queued address is sent to memory while older stores are still queued. Its response carries the memory data.
- R4: With strict ordering in force (ordering latch 1), a load that misses the queue is not sent to memory until the occupancy count is zero.
- R5: A fence request (op code 2) sees ready low while any store is queued or its write is unacknowledged. When the fence is accepted, the count is zero and every earlier store has reached memory.
- R6: A load whose address matches queued entries returns the data of the youngest matching entry one cycle after acceptance, and it issues no memory read.
- R7: With DEPTH stores queued, ready is low for a store request, and no entry is lost or overwritten.
- R8: The memory port has at most one request outstanding and holds its fields until mem_ack. When a pending missed load and a queued store both want the idle port, the load is issued first.
- R9: The ordering latch copies mode_sc only in cycles where the queue is empty. A change of mode_sc while stores are queued has no effect on a load accepted before the queue empties.
- R10: Reset clears every entry: the count is 0, the empty flag is 1, ready is 1, and no memory request or response is active. The empty flag is high exactly when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sc | input | 1 | 1 = strict ordering, 0 = relaxed; latched only when empty |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Core request accepted this cycle when high with valid |
| core_req_op | input | 2 | 0 load, 1 store, 2 fence, 3 no operation |
| core_req_addr | input | AW | Request address |
| core_req_wdata | input | DW | Store data |
| core_rsp_valid | output | 1 | One-cycle load response strobe |
| core_rsp_data | output | DW | Load response data |
| mem_req_valid | output | 1 | Memory request valid, held until mem_ack |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the outstanding request |
| mem_rdata | input | DW | Read data, valid with mem_ack on a read |
| buf_empty | output | 1 | Queue empty and no write outstanding |
| buf_count | output | CW | Number of queued stores, including one being written |

## Verification
Two things can want the single memory port at the same moment: the background drain of the queue head and a load that missed the queue. The bench provokes this by parking two stores behind a slow memory and then issuing a missed load while the first write is still outstanding. When that write is acknowledged, both requesters are waiting. A memory model logs every request with the occupancy seen at issue. The log must show write, read, write. In strict mode the same pattern must show both writes before the read, with an occupancy of zero at the read.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2,
        OP_NOP   = 2'd3
    } sb_op_e;

    typedef enum logic {
        CS_IDLE   = 1'b0,
        CS_LDWAIT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [AW-1:0] head_addr_o,
    output logic [DW-1:0] head_data_o,
    input  logic [AW-1:0] look_addr_i,
    output logic          hit_o,
    output logic [DW-1:0] hit_data_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } q_t;

    q_t q, d;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.addr[q.tail] = push_addr_i;
            d.data[q.tail] = push_data_i;
            d.tail         = nxt(q.tail);
        end
        if (pop_i) d.head = nxt(q.head);
        d.count = q.count + CW'(push_i) - CW'(pop_i);
    end

    // age-ordered search: later (younger) matches override earlier ones
    always_comb begin
        int s;
        hit_o      = 1'b0;
        hit_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s = int'(q.head) + i;
            if (s >= DEPTH) s = s - DEPTH;
            if ((CW'(i) < q.count) && (q.addr[PW'(s)] == look_addr_i)) begin
                hit_o      = 1'b1;
                hit_data_o = q.data[PW'(s)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.head  <= '0;
            q.tail  <= '0;
            q.count <= '0;
            q.addr  <= '0;
            q.data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_addr_o = q.addr[q.head];
    assign head_data_o = q.data[q.head];
    assign count_o     = q.count;
    assign full_o      = (q.count == CW'(DEPTH));
    assign empty_o     = (q.count == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/sb_memport.sv
module sb_memport #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_req_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic          st_req_i,
    input  logic [AW-1:0] st_addr_i,
    input  logic [DW-1:0] st_data_i,
    output logic          wr_done_o,
    output logic          rd_done_o,
    output logic [DW-1:0] rd_data_o,
    output logic          mem_req_valid_o,
    output logic          mem_req_write_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [DW-1:0] mem_req_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i
);
    typedef struct packed {
        logic          busy;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mp_t;

    mp_t q, d;

    always_comb begin
        d         = q;
        wr_done_o = q.busy && mem_ack_i && q.write;
        rd_done_o = q.busy && mem_ack_i && !q.write;
        rd_data_o = mem_rdata_i;
        if (q.busy) begin
            if (mem_ack_i) d.busy = 1'b0;
        end else if (ld_req_i) begin
            d.busy  = 1'b1;
            d.write = 1'b0;
            d.addr  = ld_addr_i;
        end else if (st_req_i) begin
            d.busy  = 1'b1;
            d.write = 1'b1;
            d.addr  = st_addr_i;
            d.wdata = st_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid_o = q.busy;
    assign mem_req_write_o = q.write;
    assign mem_req_addr_o  = q.addr;
    assign mem_req_wdata_o = q.wdata;

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_ack_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));
    // R8
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_valid_o && ld_req_i) |=> (mem_req_valid_o && !mem_req_write_o));
endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sc,
    input  logic          core_req_valid,
    output logic          core_req_ready,
    input  logic [1:0]    core_req_op,
    input  logic [AW-1:0] core_req_addr,
    input  logic [DW-1:0] core_req_wdata,
    output logic          core_rsp_valid,
    output logic [DW-1:0] core_rsp_data,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          buf_empty,
    output logic [CW-1:0] buf_count
);
    import sb_pkg::*;

    typedef struct packed {
        ctl_state_e    st;
        logic [AW-1:0] ld_addr;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
        logic          mode_sc;
    } ctl_t;

    ctl_t q, d;

    logic          push, full, empty, hit;
    logic [DW-1:0] hit_data, head_data, rd_data;
    logic [AW-1:0] head_addr;
    logic          wr_done, rd_done, ld_req, accept;
    logic          is_load, is_store, is_fence;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_addr_i(core_req_addr), .push_data_i(core_req_wdata),
        .pop_i(wr_done),
        .head_addr_o(head_addr), .head_data_o(head_data),
        .look_addr_i(core_req_addr), .hit_o(hit), .hit_data_o(hit_data),
        .count_o(buf_count), .full_o(full), .empty_o(empty)
    );

    sb_memport #(.AW(AW), .DW(DW)) memport_i (
        .clk(clk), .rst_n(rst_n),
        .ld_req_i(ld_req), .ld_addr_i(q.ld_addr),
        .st_req_i(!empty), .st_addr_i(head_addr), .st_data_i(head_data),
        .wr_done_o(wr_done), .rd_done_o(rd_done), .rd_data_o(rd_data),
        .mem_req_valid_o(mem_req_valid), .mem_req_write_o(mem_req_write),
        .mem_req_addr_o(mem_req_addr), .mem_req_wdata_o(mem_req_wdata),
        .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    always_comb begin
        is_load  = (core_req_op == OP_LOAD);
        is_store = (core_req_op == OP_STORE);
        is_fence = (core_req_op == OP_FENCE);

        core_req_ready = (q.st == CS_IDLE) &&
                         (is_store ? !full : (is_fence ? empty : 1'b1));
        accept = core_req_valid && core_req_ready;
        push   = accept && is_store;
        ld_req = (q.st == CS_LDWAIT) && (!q.mode_sc || empty);

        d           = q;
        d.rsp_valid = 1'b0;
        if (accept && is_load) begin
            if (hit) begin
                d.rsp_valid = 1'b1;
                d.rsp_data  = hit_data;
            end else begin
                d.st      = CS_LDWAIT;
                d.ld_addr = core_req_addr;
            end
        end
        if ((q.st == CS_LDWAIT) && rd_done) begin
            d.st        = CS_IDLE;
            d.rsp_valid = 1'b1;
            d.rsp_data  = rd_data;
        end
        if (empty) d.mode_sc = mode_sc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= CS_IDLE;
            q.ld_addr   <= '0;
            q.rsp_valid <= 1'b0;
            q.rsp_data  <= '0;
            q.mode_sc   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign core_rsp_valid = q.rsp_valid;
    assign core_rsp_data  = q.rsp_data;
    assign buf_empty      = empty;

    // R1
    store_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !wr_done) |=> (buf_count == $past(buf_count) + CW'(1)));
    // R4
    sc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && !mem_req_write && q.mode_sc) |-> buf_empty);
    // R5
    fence_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && is_fence && core_req_ready) |-> (buf_empty && !mem_req_valid));
    // R6
    fwd_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_load && hit) |=> (core_rsp_valid && (q.st == CS_IDLE)));
endmodule

// File: tb/tso_wbuf_tb.sv
`timescale 1ns/1ps
module tso_wbuf_tb_top;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sc = 1'b0;
    logic          core_req_valid = 1'b0;
    logic          core_req_ready;
    logic [1:0]    core_req_op = 2'd3;
    logic [AW-1:0] core_req_addr = '0;
    logic [DW-1:0] core_req_wdata = '0;
    logic          core_rsp_valid;
    logic [DW-1:0] core_rsp_data;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          buf_empty;
    logic [CW-1:0] buf_count;

    always #2.5 clk = ~clk;

    tso_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sc(mode_sc),
        .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
        .core_req_op(core_req_op), .core_req_addr(core_req_addr),
        .core_req_wdata(core_req_wdata),
        .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_empty(buf_empty), .buf_count(buf_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int lat = 4;

    // memory model and request log
    logic [DW-1:0] mem_model [256];
    logic          lg_wr   [64];
    logic [AW-1:0] lg_addr [64];
    int            lg_cnt  [64];
    int            nlog = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_model[i] = 16'hA000 | 16'(i);
    end

    // memory responder: logs each request once, acks after lat cycles
    initial begin
        bit seen;
        int w;
        seen = 0;
        w = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0; seen = 0; w = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req_valid) begin
                if (!seen) begin
                    seen = 1;
                    if (nlog < 64) begin
                        lg_wr[nlog]   = mem_req_write;
                        lg_addr[nlog] = mem_req_addr;
                        lg_cnt[nlog]  = int'(buf_count);
                        nlog++;
                    end
                end
                w++;
                if (w >= lat) begin
                    if (mem_req_write) mem_model[mem_req_addr] = mem_req_wdata;
                    else               mem_rdata = mem_model[mem_req_addr];
                    mem_ack = 1'b1;
                    seen = 0;
                    w = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] dat, output int waited);
        waited = 0;
        @(negedge clk);
        core_req_valid = 1'b1;
        core_req_op    = op;
        core_req_addr  = a;
        core_req_wdata = dat;
        #1;
        while (!core_req_ready) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(posedge clk);
        #1;
        core_req_valid = 1'b0;
        core_req_op    = 2'd3;
    endtask

    task automatic get_rsp(output logic [DW-1:0] dat, output int cyc);
        cyc = 0;
        dat = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (core_rsp_valid) begin
                dat = core_rsp_data;
                break;
            end
            if (cyc > 500) break;
        end
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (!(buf_empty && !mem_req_valid) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(buf_count == 0, "R10", "reset count", int'(buf_count), 0);
        chk(buf_empty == 1'b1, "R10", "reset empty", int'(buf_empty), 1);
        chk(core_req_ready == 1'b1, "R10", "reset ready", int'(core_req_ready), 1);
        chk(!mem_req_valid && !core_rsp_valid, "R10", "reset idle ports",
            int'({mem_req_valid, core_rsp_valid}), 0);
    endtask

    task automatic t_store_stream();
        int w;
        lat = 10;
        nlog = 0;
        for (int i = 0; i < 3; i++) begin
            issue(2'd1, 8'h10 + 8'(i), 16'h0100 + 16'(i), w);
            chk(w == 0, "R1", "store accepted without memory wait", w, 0);
        end
        chk(buf_count == 3, "R1", "count after three stores", int'(buf_count), 3);
        chk(buf_empty == 1'b0, "R10", "empty flag low when count nonzero", int'(buf_empty), 0);
        drain();
        chk(nlog == 3, "R2", "write count", nlog, 3);
        for (int i = 0; i < 3; i++)
            chk(lg_wr[i] && lg_addr[i] == 8'h10 + 8'(i), "R2", "write order addr",
                int'(lg_addr[i]), 16 + i);
        chk(mem_model[8'h12] == 16'h0102, "R2", "memory content", int'(mem_model[8'h12]), 16'h0102);
    endtask

    task automatic t_bypass();
        int w, c;
        logic [DW-1:0] r;
        mode_sc = 1'b0;
        repeat (2) @(negedge clk);
        lat = 8;
        nlog = 0;
        issue(2'd1, 8'h20, 16'h2020, w);
        issue(2'd1, 8'h21, 16'h2121, w);
        issue(2'd0, 8'h30, 16'h0, w);
        get_rsp(r, c);
        chk(r == 16'hA030, "R3", "bypassing load data", int'(r), 16'hA030);
        drain();
        chk(nlog == 3, "R8", "request count", nlog, 3);
        chk(!lg_wr[1] && lg_addr[1] == 8'h30, "R8", "load wins port after first write",
            int'(lg_addr[1]), 16'h30);
        chk(lg_cnt[1] > 0, "R3", "stores still queued at load issue", lg_cnt[1], 1);
        chk(lg_wr[2] && lg_addr[2] == 8'h21, "R2", "second store after load", int'(lg_addr[2]), 16'h21);
    endtask

    task automatic t_sc_order();
        int w, c;
        logic [DW-1:0] r;
        mode_sc = 1'b1;
        repeat (3) @(negedge clk);
        lat = 8;
        nlog = 0;
        issue(2'd1, 8'h40, 16'h4040, w);
        issue(2'd1, 8'h41, 16'h4141, w);
        issue(2'd0, 8'h50, 16'h0, w);
        get_rsp(r, c);
        chk(r == 16'hA050, "R4", "strict load data", int'(r), 16'hA050);
        drain();
        chk(nlog == 3 && !lg_wr[2] && lg_addr[2] == 8'h50, "R4", "load issued last",
            int'(lg_addr[2]), 16'h50);
        chk(lg_cnt[2] == 0, "R4", "count at strict load issue", lg_cnt[2], 0);
        mode_sc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_forward();
        int w, c, reads;
        logic [DW-1:0] r;
        lat = 12;
        nlog = 0;
        issue(2'd1, 8'h60, 16'h1111, w);
        issue(2'd1, 8'h61, 16'h6161, w);
        issue(2'd1, 8'h60, 16'h2222, w);
        issue(2'd0, 8'h60, 16'h0, w);
        get_rsp(r, c);
        chk(r == 16'h2222, "R6", "youngest match forwarded", int'(r), 16'h2222);
        chk(c == 1, "R6", "forward latency", c, 1);
        drain();
        reads = 0;
        for (int i = 0; i < nlog; i++) if (!lg_wr[i]) reads++;
        chk(reads == 0, "R6", "no memory read on hit", reads, 0);
        chk(mem_model[8'h60] == 16'h2222, "R2", "last store wins in memory",
            int'(mem_model[8'h60]), 16'h2222);
    endtask

    task automatic t_full();
        int w;
        lat = 30;
        nlog = 0;
        for (int i = 0; i < DEPTH; i++) issue(2'd1, 8'hB0 + 8'(i), 16'hB000 + 16'(i), w);
        @(negedge clk);
        core_req_valid = 1'b1;
        core_req_op    = 2'd1;
        core_req_addr  = 8'hB4;
        core_req_wdata = 16'hB004;
        #1;
        chk(core_req_ready == 1'b0, "R7", "ready low when full", int'(core_req_ready), 0);
        chk(buf_count == CW'(DEPTH), "R7", "count at full", int'(buf_count), DEPTH);
        core_req_valid = 1'b0;
        issue(2'd1, 8'hB4, 16'hB004, w);
        chk(w > 0, "R7", "fifth store waited", w, 1);
        drain();
        chk(nlog == DEPTH + 1, "R7", "no entry lost", nlog, DEPTH + 1);
        for (int i = 0; i <= DEPTH; i++)
            chk(mem_model[8'hB0 + 8'(i)] == 16'hB000 + 16'(i), "R7", "entry content",
                int'(mem_model[8'hB0 + 8'(i)]), 16'hB000 + i);
    endtask

    task automatic t_fence();
        int w;
        lat = 6;
        nlog = 0;
        for (int i = 0; i < 3; i++) issue(2'd1, 8'h70 + 8'(i), 16'h7000 + 16'(i), w);
        @(negedge clk);
        core_req_valid = 1'b1;
        core_req_op    = 2'd2;
        #1;
        chk(core_req_ready == 1'b0, "R5", "fence held while queued", int'(core_req_ready), 0);
        core_req_valid = 1'b0;
        issue(2'd2, 8'h00, 16'h0, w);
        chk(buf_count == 0, "R5", "count at fence accept", int'(buf_count), 0);
        chk(nlog == 3, "R5", "writes done at fence accept", nlog, 3);
        chk(mem_model[8'h72] == 16'h7002, "R5", "last write visible",
            int'(mem_model[8'h72]), 16'h7002);
    endtask

    task automatic t_mode_sample();
        int w, c;
        logic [DW-1:0] r;
        mode_sc = 1'b0;
        repeat (3) @(negedge clk);
        lat = 8;
        nlog = 0;
        issue(2'd1, 8'h80, 16'h8080, w);
        issue(2'd1, 8'h81, 16'h8181, w);
        mode_sc = 1'b1;
        issue(2'd0, 8'h90, 16'h0, w);
        get_rsp(r, c);
        drain();
        chk(!lg_wr[1] && lg_addr[1] == 8'h90 && lg_cnt[1] > 0, "R9",
            "mode change ignored while queued", lg_cnt[1], 1);
        nlog = 0;
        issue(2'd1, 8'h82, 16'h8282, w);
        issue(2'd0, 8'h91, 16'h0, w);
        get_rsp(r, c);
        drain();
        chk(nlog == 2 && !lg_wr[1] && lg_cnt[1] == 0, "R9", "strict mode latched when empty",
            lg_cnt[1], 0);
        chk(r == 16'hA091, "R9", "load data", int'(r), 16'hA091);
        mode_sc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_mid_reset();
        int w;
        lat = 40;
        issue(2'd1, 8'hC0, 16'hC0C0, w);
        issue(2'd1, 8'hC1, 16'hC1C1, w);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(buf_count == 0 && buf_empty, "R10", "reset clears entries", int'(buf_count), 0);
        chk(core_req_ready == 1'b1 && !mem_req_valid, "R10", "idle after reset",
            int'({core_req_ready, mem_req_valid}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_stream();
        t_bypass();
        t_sc_order();
        t_forward();
        t_full();
        t_fence();
        t_mode_sample();
        t_mid_reset();
        finish_run();
    end
endmodule